// File: doc/BRIEF.md
# Shared-Clock Dual-Port Block RAM with Per-Port Clock Enable

This block is an on-chip word memory with two fully independent access ports that both run from a single clock. Each port can write and read. A write takes effect only when the port's select, write strobe and clock enable are all high, and it updates only the byte lanes whose lane enables are set. There is no read request input. On every clock edge where a port is enabled, that port loads its address register and also loads its output register with the word at the previously registered address.

Each port has its own clock enable. Pulling it low freezes both the address register and the output register of that port. The read data then holds steady even if the address input moves or the other port rewrites the stored word.

Every edge reads the array before it applies any write. Because of this, a port that reads a word while either port writes that same word in the same cycle gets the old contents. Two writes to one address in the same cycle are outside the contract. Reset clears both output registers and both address registers to zero, and leaves the stored words intact.

Top module: `dpr_ram_top`

## Requirements
- R1: There is no read strobe. On each rising edge with the clock enable high, the port loads its address input into its address register. At the same edge it loads its read data output with the stored word at the address that the register held before that edge. A word therefore appears on the read data output after the second enabled edge at which its address is presented.
- R2: While a port's clock enable is low, that port's address register and read data output keep their values. This holds even if the address input changes or the stored word at the held address is rewritten. At the next enabled edge, the read uses the held address, not the new address input.
- R3: A port writes the array only on an edge where its select, write strobe and clock enable are all high (all active high). If any one of the three is low, the stored word is left unchanged.
- R4: Lane enable bit i (active high) controls data bits [8i+7:8i]. Lanes whose enable is low keep their previous contents. With all four enables set, one write replaces the whole 32-bit word.
- R5: Suppose one port reads an address on an edge at which the other port writes that same address. The reading port returns the previous contents. A later read returns the new word.
- R6: Suppose a port reads an address on the same edge at which it writes that address itself. That port also returns the previous contents.
- R7: While reset (active high) is sampled high, both read data outputs and both address registers are cleared to zero. Stored words are kept through reset.
- R8: The two ports work independently in the same cycle. Both can write different addresses, and both can read, without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| pa_ce | input | 1 | Port A clock enable |
| pa_cs | input | 1 | Port A select |
| pa_we | input | 1 | Port A write strobe |
| pa_addr | input | 10 | Port A word address |
| pa_wdata | input | 32 | Port A write data |
| pa_be | input | 4 | Port A byte-lane enables |
| pa_rdata | output | 32 | Port A registered read data |
| pb_ce | input | 1 | Port B clock enable |
| pb_cs | input | 1 | Port B select |
| pb_we | input | 1 | Port B write strobe |
| pb_addr | input | 10 | Port B word address |
| pb_wdata | input | 32 | Port B write data |
| pb_be | input | 4 | Port B byte-lane enables |
| pb_rdata | output | 32 | Port B registered read data |

## Verification
A word appears on the read data output one enabled edge after the edge that registered its address. A write is seen by any read whose data-sampling edge comes strictly after the write edge, and a read sampled on the write edge itself returns the old word. The bench changes inputs on the falling edge. Its behavioural model of the array, the address registers and the output registers updates on the rising edge, reading before writing. The design's outputs are compared with the model at the following falling edge, in every cycle. The directed hold, collision and byte-lane cases count their enabled edges exactly, and they check literal values at the falling edge after the data edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int BYTE_BITS = 8;
    localparam int NPORT     = 2;
endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int NB    = DW / dpr_pkg::BYTE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_a,
    input  logic [AW-1:0] wr_addr_a,
    input  logic [DW-1:0] wr_data_a,
    input  logic [NB-1:0] wr_be_a,
    input  logic          wr_en_b,
    input  logic [AW-1:0] wr_addr_b,
    input  logic [DW-1:0] wr_data_b,
    input  logic [NB-1:0] wr_be_b,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_word_a,
    output logic [DW-1:0] rd_word_b
);
    localparam int BB = dpr_pkg::BYTE_BITS;

    logic [DW-1:0] mem_q [DEPTH];

    // Reads see the contents before this edge's writes land.
    always_comb begin
        rd_word_a = mem_q[rd_addr_a];
        rd_word_b = mem_q[rd_addr_b];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (wr_en_a && wr_be_a[i]) mem_q[wr_addr_a][i*BB +: BB] <= wr_data_a[i*BB +: BB];
            if (wr_en_b && wr_be_b[i]) mem_q[wr_addr_b][i*BB +: BB] <= wr_data_b[i*BB +: BB];
        end
    end

    // R4: a lane with its enable low keeps its old byte.
    for (genvar g = 0; g < NB; g++) begin : g_lane_chk
        a_r4_lane_kept: assert property (@(posedge clk) disable iff (rst)
            (wr_en_a && !wr_be_a[g] && !(wr_en_b && wr_addr_b == wr_addr_a))
            |=> mem_q[$past(wr_addr_a)][g*BB +: BB] == $past(mem_q[wr_addr_a][g*BB +: BB]))
            else $error("R4 disabled lane changed");
    end
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
    parameter int DW = 32,
    parameter int AW = 10,
    parameter int NB = DW / dpr_pkg::BYTE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] be,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [NB-1:0] wr_be
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_en   = cs & we & ce;
        wr_addr = addr;
        wr_data = wdata;
        wr_be   = be;
        if (ce) begin
            st_d.addr  = addr;
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign raddr = st_q.addr;
    assign rdata = st_q.rdata;

    a_r1_enabled_load: assert property (@(posedge clk) disable iff (rst)
        ce |=> (rdata == $past(rd_word)) && (raddr == $past(addr)))
        else $error("R1 enabled edge did not load");

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(rdata) && $stable(raddr))
        else $error("R2 disabled port moved");

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (rdata == '0) && (raddr == '0))
        else $error("R7 reset did not clear");
endmodule

// File: rtl/dpr_ram_top.sv
module dpr_ram_top #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int NB    = DW / dpr_pkg::BYTE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pa_ce,
    input  logic          pa_cs,
    input  logic          pa_we,
    input  logic [AW-1:0] pa_addr,
    input  logic [DW-1:0] pa_wdata,
    input  logic [NB-1:0] pa_be,
    output logic [DW-1:0] pa_rdata,
    input  logic          pb_ce,
    input  logic          pb_cs,
    input  logic          pb_we,
    input  logic [AW-1:0] pb_addr,
    input  logic [DW-1:0] pb_wdata,
    input  logic [NB-1:0] pb_be,
    output logic [DW-1:0] pb_rdata
);
    localparam int NP = dpr_pkg::NPORT;

    logic          ce_v    [NP];
    logic          cs_v    [NP];
    logic          we_v    [NP];
    logic [AW-1:0] addr_v  [NP];
    logic [DW-1:0] wd_v    [NP];
    logic [NB-1:0] be_v    [NP];
    logic [DW-1:0] word_v  [NP];
    logic [AW-1:0] raddr_v [NP];
    logic [DW-1:0] rdata_v [NP];
    logic          wen_v   [NP];
    logic [AW-1:0] waddr_v [NP];
    logic [DW-1:0] wdat_v  [NP];
    logic [NB-1:0] wbe_v   [NP];

    always_comb begin
        ce_v[0] = pa_ce;    ce_v[1] = pb_ce;
        cs_v[0] = pa_cs;    cs_v[1] = pb_cs;
        we_v[0] = pa_we;    we_v[1] = pb_we;
        addr_v[0] = pa_addr;  addr_v[1] = pb_addr;
        wd_v[0] = pa_wdata; wd_v[1] = pb_wdata;
        be_v[0] = pa_be;    be_v[1] = pb_be;
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        dpr_port #(.DW(DW), .AW(AW), .NB(NB)) u_port (
            .clk(clk), .rst(rst),
            .ce(ce_v[p]), .cs(cs_v[p]), .we(we_v[p]),
            .addr(addr_v[p]), .wdata(wd_v[p]), .be(be_v[p]),
            .rd_word(word_v[p]),
            .raddr(raddr_v[p]), .rdata(rdata_v[p]),
            .wr_en(wen_v[p]), .wr_addr(waddr_v[p]),
            .wr_data(wdat_v[p]), .wr_be(wbe_v[p])
        );
    end

    dpr_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .NB(NB)) u_store (
        .clk(clk), .rst(rst),
        .wr_en_a(wen_v[0]), .wr_addr_a(waddr_v[0]), .wr_data_a(wdat_v[0]), .wr_be_a(wbe_v[0]),
        .wr_en_b(wen_v[1]), .wr_addr_b(waddr_v[1]), .wr_data_b(wdat_v[1]), .wr_be_b(wbe_v[1]),
        .rd_addr_a(raddr_v[0]), .rd_addr_b(raddr_v[1]),
        .rd_word_a(word_v[0]), .rd_word_b(word_v[1])
    );

    assign pa_rdata = rdata_v[0];
    assign pb_rdata = rdata_v[1];

    // R5: a read colliding with the other port's write returns the pre-write word.
    a_r5_old_data_a: assert property (@(posedge clk) disable iff (rst)
        (pa_ce && wen_v[1] && waddr_v[1] == raddr_v[0]) |=> pa_rdata == $past(word_v[0]))
        else $error("R5 port A collision not old data");

    a_r5_old_data_b: assert property (@(posedge clk) disable iff (rst)
        (pb_ce && wen_v[0] && waddr_v[0] == raddr_v[1]) |=> pb_rdata == $past(word_v[1]))
        else $error("R5 port B collision not old data");
endmodule

// File: tb/dpr_ram_top_test.sv
`timescale 1ns/100ps
module dpr_ram_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce [2];
    logic        cs [2];
    logic        we [2];
    logic [9:0]  addr [2];
    logic [31:0] wd [2];
    logic [3:0]  be [2];
    logic [31:0] rda, rdb;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur = "R7";

    logic [31:0] m_mem [1024];
    bit          m_known [1024];
    logic [9:0]  m_aq [2];
    logic [31:0] m_rd [2];
    bit          m_rk [2];

    always #2.5 clk = ~clk;

    dpr_ram_top uut (
        .clk(clk), .rst(rst),
        .pa_ce(ce[0]), .pa_cs(cs[0]), .pa_we(we[0]), .pa_addr(addr[0]),
        .pa_wdata(wd[0]), .pa_be(be[0]), .pa_rdata(rda),
        .pb_ce(ce[1]), .pb_cs(cs[1]), .pb_we(we[1]), .pb_addr(addr[1]),
        .pb_wdata(wd[1]), .pb_be(be[1]), .pb_rdata(rdb)
    );

    function automatic logic [31:0] pat(int a);
        return 32'hC0DE_0000 ^ (a * 32'h0001_9E37);
    endfunction

    // Reference model: reads before writes on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                m_rd[p] = '0; m_aq[p] = '0; m_rk[p] = 1;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (ce[p]) begin
                    m_rd[p] = m_mem[m_aq[p]];
                    m_rk[p] = m_known[m_aq[p]];
                    m_aq[p] = addr[p];
                end
            end
            for (int p = 0; p < 2; p++) begin
                if (cs[p] && we[p] && ce[p]) begin
                    for (int k = 0; k < 4; k++)
                        if (be[p][k]) m_mem[addr[p]][k*8 +: 8] = wd[p][k*8 +: 8];
                    if (be[p] == 4'hF) m_known[addr[p]] = 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (m_rk[0]) chk(rda === m_rd[0], cur, rda, m_rd[0]);
        if (m_rk[1]) chk(rdb === m_rd[1], cur, rdb, m_rd[1]);
    endtask

    task automatic idle();
        for (int p = 0; p < 2; p++) begin
            ce[p] = 0; cs[p] = 0; we[p] = 0; be[p] = 4'hF; addr[p] = '0; wd[p] = '0;
        end
    endtask

    task automatic read_a(logic [9:0] a);
        ce[0] = 1; cs[0] = 0; we[0] = 0; addr[0] = a;
        step(); step();
    endtask

    initial begin
        logic [31:0] exp5;
        for (int i = 0; i < 1024; i++) m_known[i] = 0;
        m_rk[0] = 0; m_rk[1] = 0;
        idle();
        step(); step(); step();
        chk(rda === 32'h0, "R7", rda, 32'h0);
        chk(rdb === 32'h0, "R7", rdb, 32'h0);
        rst = 0;

        // R8: both ports write in the same cycles
        cur = "R8";
        for (int i = 0; i < 512; i++) begin
            ce[0] = 1; cs[0] = 1; we[0] = 1; addr[0] = 10'(2*i);   wd[0] = pat(2*i);
            ce[1] = 1; cs[1] = 1; we[1] = 1; addr[1] = 10'(2*i+1); wd[1] = pat(2*i+1);
            step();
        end
        idle();
        ce[1] = 1; addr[1] = 10'd77;
        read_a(10'd76);
        chk(rda === pat(76), "R8", rda, pat(76));
        chk(rdb === pat(77), "R8", rdb, pat(77));
        idle();

        // R4: partial lane write
        cur = "R4";
        ce[0] = 1; cs[0] = 1; we[0] = 1; addr[0] = 10'd5; wd[0] = 32'hAABBCCDD; be[0] = 4'b0101;
        step();
        be[0] = 4'hF;
        exp5 = {pat(5)[31:24], 8'hBB, pat(5)[15:8], 8'hDD};
        read_a(10'd5);
        chk(rda === exp5, "R4", rda, exp5);

        // R3: any of select, strobe, enable low blocks the write
        cur = "R3";
        idle();
        ce[0] = 1; cs[0] = 0; we[0] = 1; addr[0] = 10'd40; wd[0] = 32'h1111_1111; step();
        cs[0] = 1; we[0] = 0; wd[0] = 32'h2222_2222; step();
        ce[0] = 0; we[0] = 1; wd[0] = 32'h3333_3333; step();
        cs[0] = 0; we[0] = 0;
        read_a(10'd40);
        chk(rda === pat(40), "R3", rda, pat(40));

        // R2: hold while enable is low
        cur = "R2";
        read_a(10'd10);
        chk(rda === pat(10), "R2", rda, pat(10));
        ce[0] = 0; addr[0] = 10'd99;
        ce[1] = 1; cs[1] = 1; we[1] = 1; addr[1] = 10'd10; wd[1] = 32'h5A5A_0010;
        step();
        idle(); addr[0] = 10'd99;
        step(); step();
        chk(rda === pat(10), "R2", rda, pat(10));
        ce[0] = 1; addr[0] = 10'd99;
        step();
        chk(rda === 32'h5A5A_0010, "R2", rda, 32'h5A5A_0010);

        // R5: cross-port collision returns old data
        cur = "R5";
        idle();
        ce[0] = 1; addr[0] = 10'd20; step();
        ce[1] = 1; cs[1] = 1; we[1] = 1; addr[1] = 10'd20; wd[1] = 32'hFEED_0020;
        step();
        chk(rda === pat(20), "R5", rda, pat(20));
        ce[1] = 0; cs[1] = 0; we[1] = 0;
        step();
        chk(rda === 32'hFEED_0020, "R5", rda, 32'hFEED_0020);

        // R6: same-port read of the word being written
        cur = "R6";
        idle();
        ce[0] = 1; addr[0] = 10'd30; step();
        cs[0] = 1; we[0] = 1; wd[0] = 32'hBEEF_0030;
        step();
        chk(rda === pat(30), "R6", rda, pat(30));
        cs[0] = 0; we[0] = 0;
        step();
        chk(rda === 32'hBEEF_0030, "R6", rda, 32'hBEEF_0030);

        // R1: random traffic on both ports against the model
        cur = "R1";
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < 2; p++) begin
                ce[p] = ($urandom % 10) < 7;
                cs[p] = $urandom % 2;
                we[p] = $urandom % 2;
                addr[p] = 10'($urandom % 64);
                wd[p] = $urandom;
                be[p] = 4'($urandom);
            end
            if (cs[0] && we[0] && ce[0] && cs[1] && we[1] && ce[1] && addr[0] == addr[1])
                we[1] = 0;
            step();
        end

        // R7: reset mid-run clears outputs, keeps contents
        cur = "R7";
        idle();
        rst = 1;
        step();
        chk(rda === 32'h0, "R7", rda, 32'h0);
        chk(rdb === 32'h0, "R7", rdb, 32'h0);
        rst = 0;
        read_a(10'd700);
        chk(rda === pat(700), "R7", rda, pat(700));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule